// File: doc/BRIEF.md
# GPIO edge interrupt controller

This block watches a small set of general-purpose input lines and turns their transitions into interrupt requests. Every line owns two independent trigger enables, one for low-to-high and one for high-to-low transitions, and two matching pending flags. A flag is latched when its transition arrives while its enable is set, and it stays set until software writes a one to the matching bit of the clear register. Only transitions can trigger. There is no level-sensitive mode.

Software reaches the block through a word-wide register port. A write takes effect on the clock edge that samples it. A read returns its data one cycle after the request. The rising controls sit in the low byte lane, with bit n belonging to line n. The falling controls sit in the second byte lane, with bit 8+n belonging to line n. The block drives one combined request line and a vector number. The vector is a programmable base plus the index of the lowest-numbered line that has any pending flag.

Each input passes through a two-stage synchroniser and a one-cycle delay stage before the transition is detected. From the input change to a raised request takes four clock edges.

Top module: `gpio_edge_intc`

## Requirements
- R1: After synchronous reset, the enable, pending and vector-base registers are all 0, `irq_o` is 0 and `vec_o` is 0.
- R2: A low-to-high transition on line n while enable bit n is 1 sets status bit n.
- R3: A high-to-low transition on line n while enable bit 8+n is 1 sets status bit 8+n.
- R4: A transition whose own enable bit is 0 sets no pending flag, even when the opposite-direction enable of that line is 1.
- R5: Writing the clear register (address 1) clears each pending flag whose bit is 1 in the written word. Bits written as 0 leave their flags unchanged.
- R6: When a new enabled transition and a clear of the same flag arrive in the same cycle, the flag stays set.
- R7: `irq_o` is 1 exactly when some pending flag has its enable bit set. Clearing an enable lowers `irq_o` and leaves the pending flag visible in the status register (address 2).
- R8: `vec_o` equals the vector base (address 3) plus the index of the lowest-numbered line that has any pending flag.
- R9: The enable register (address 0) reads back as written in bits 0..6 and 8..14. Bits 7 and 15..31 read as 0. The vector base keeps only its low 8 bits. The status register ignores writes. The clear register reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_i | input | 7 | Asynchronous input lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address: 0 enable, 1 clear, 2 status, 3 vector base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | Combined interrupt request (registered) |
| vec_o | output | 8 | Vector base plus lowest pending line index (registered) |

## Verification
A pending flag that is lost, stuck or placed in the wrong lane shows up in the status word. It also moves `irq_o` and `vec_o` one edge after the flag itself changes, four edges after the input transition. A clear that beats a simultaneous new transition leaves the status bit at 0, where it should read 1. This can be seen on the first status read after the race. A priority-encoder fault shows as a wrong `vec_o` when two lines are pending, and it changes again as soon as the lower line is cleared.

// File: rtl/gei_pkg.sv
package gei_pkg;
  localparam int unsigned LANE   = 8;
  localparam int unsigned A_EN   = 0;
  localparam int unsigned A_CLR  = 1;
  localparam int unsigned A_STAT = 2;
  localparam int unsigned A_BASE = 3;
endpackage

// File: rtl/gei_edge_sync.sv
module gei_edge_sync #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q[g] <= 1'b0;
          sync_q[g] <= 1'b0;
          prev_q[g] <= 1'b0;
        end else begin
          meta_q[g] <= pin_i[g];
          sync_q[g] <= meta_q[g];
          prev_q[g] <= sync_q[g];
        end
      end
      assign rise_o[g] =  sync_q[g] & ~prev_q[g];
      assign fall_o[g] = ~sync_q[g] &  prev_q[g];
    end
  endgenerate
endmodule

// File: rtl/gei_pend.sv
module gei_pend #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] fall_i,
  input  logic [N-1:0] en_r_i,
  input  logic [N-1:0] en_f_i,
  input  logic [N-1:0] clr_r_i,
  input  logic [N-1:0] clr_f_i,
  output logic [N-1:0] pr_o,
  output logic [N-1:0] pf_o
);
  logic [N-1:0] set_r, set_f;

  assign set_r = rise_i & en_r_i;
  assign set_f = fall_i & en_f_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pr_o <= '0;
      pf_o <= '0;
    end else begin
      pr_o <= (pr_o & ~clr_r_i) | set_r;
      pf_o <= (pf_o & ~clr_f_i) | set_f;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chk
      p_rise_needs_edge_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(pr_o[g]) |-> $past(rise_i[g] && en_r_i[g]));
      p_fall_needs_edge_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pf_o[g]) |-> $past(fall_i[g] && en_f_i[g]));
      p_rise_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $past(clr_r_i[g] && !set_r[g]) |-> !pr_o[g]);
      p_fall_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $past(clr_f_i[g] && !set_f[g]) |-> !pf_o[g]);
      p_rise_beats_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $past(set_r[g]) |-> pr_o[g]);
      p_fall_beats_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $past(set_f[g]) |-> pf_o[g]);
    end
  endgenerate
endmodule

// File: rtl/gei_vec.sv
module gei_vec #(
  parameter int unsigned N  = 7,
  parameter int unsigned VW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pr_i,
  input  logic [N-1:0]  pf_i,
  input  logic [N-1:0]  en_r_i,
  input  logic [N-1:0]  en_f_i,
  input  logic [VW-1:0] base_i,
  output logic          irq_o,
  output logic [VW-1:0] vec_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  any_p, act;
  logic [IW-1:0] low_idx;

  assign any_p = pr_i | pf_i;
  assign act   = (pr_i & en_r_i) | (pf_i & en_f_i);

  always_comb begin
    low_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (any_p[i]) low_idx = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      vec_o <= '0;
    end else begin
      irq_o <= |act;
      vec_o <= base_i + VW'(low_idx);
    end
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && vec_o == '0));
  p_irq_needs_pending_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|any_p));
endmodule

// File: rtl/gpio_edge_intc.sv
module gpio_edge_intc
  import gei_pkg::*;
#(
  parameter int unsigned NSRC = 7,
  parameter int unsigned VW   = 8,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] gpio_i,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o,
  output logic [VW-1:0]   vec_o
);
  logic [NSRC-1:0] rise, fall, en_r, en_f, clr_r, clr_f, pr, pf;
  logic [VW-1:0]   base_q;
  logic [DW-1:0]   en_word, stat_word, base_word;
  logic            wr_en, wr_clr, wr_base;

  assign wr_en   = bus_wr && (bus_addr == AW'(A_EN));
  assign wr_clr  = bus_wr && (bus_addr == AW'(A_CLR));
  assign wr_base = bus_wr && (bus_addr == AW'(A_BASE));

  assign clr_r = wr_clr ? bus_wdata[NSRC-1:0]    : '0;
  assign clr_f = wr_clr ? bus_wdata[LANE +: NSRC] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_r   <= '0;
      en_f   <= '0;
      base_q <= '0;
    end else begin
      if (wr_en) begin
        en_r <= bus_wdata[NSRC-1:0];
        en_f <= bus_wdata[LANE +: NSRC];
      end
      if (wr_base) base_q <= bus_wdata[VW-1:0];
    end
  end

  always_comb begin
    en_word   = '0;
    stat_word = '0;
    base_word = '0;
    en_word[NSRC-1:0]      = en_r;
    en_word[LANE +: NSRC]  = en_f;
    stat_word[NSRC-1:0]    = pr;
    stat_word[LANE +: NSRC] = pf;
    base_word[VW-1:0]      = base_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        AW'(A_EN):   bus_rdata <= en_word;
        AW'(A_STAT): bus_rdata <= stat_word;
        AW'(A_BASE): bus_rdata <= base_word;
        default:     bus_rdata <= '0;
      endcase
    end
  end

  gei_edge_sync #(.N(NSRC)) u_sync (
    .clk(clk), .rst(rst), .pin_i(gpio_i), .rise_o(rise), .fall_o(fall)
  );

  gei_pend #(.N(NSRC)) u_pend (
    .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall),
    .en_r_i(en_r), .en_f_i(en_f), .clr_r_i(clr_r), .clr_f_i(clr_f),
    .pr_o(pr), .pf_o(pf)
  );

  gei_vec #(.N(NSRC), .VW(VW)) u_vec (
    .clk(clk), .rst(rst), .pr_i(pr), .pf_i(pf), .en_r_i(en_r), .en_f_i(en_f),
    .base_i(base_q), .irq_o(irq_o), .vec_o(vec_o)
  );

  p_rdata_reset_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !$past(bus_rd)) |-> bus_rdata == '0);
  p_enable_holds_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!bus_wr) |-> $stable(en_word));
endmodule

// File: tb/tb_gpio_edge_intc.sv
module tb_gpio_edge_intc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  gpio = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic [7:0]  vec_o;
  int nvec = 0;
  int nerr = 0;
  logic [31:0] rd;

  gpio_edge_intc dut (
    .clk(clk), .rst(rst), .gpio_i(gpio), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .vec_o(vec_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    rdreg(2'd0, rd); chk("R1 enable", rd, 32'h0);
    rdreg(2'd2, rd); chk("R1 status", rd, 32'h0);
    rdreg(2'd3, rd); chk("R1 base", rd, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 vec", {24'b0, vec_o}, 32'h0);
  endtask

  task automatic t_regs;
    wr(2'd0, 32'hFFFF_FFFF); rdreg(2'd0, rd); chk("R9 enable mask", rd, 32'h0000_7F7F);
    wr(2'd3, 32'h0000_01FF); rdreg(2'd3, rd); chk("R9 base width", rd, 32'h0000_00FF);
    wr(2'd2, 32'h0000_FFFF); rdreg(2'd2, rd); chk("R9 status read-only", rd, 32'h0);
    rdreg(2'd1, rd); chk("R9 clear reads zero", rd, 32'h0);
    wr(2'd0, 32'h0); wr(2'd3, 32'h40);
  endtask

  task automatic t_rise;
    wr(2'd0, 32'h0008);
    gpio[3] = 1'b1; settle(6);
    rdreg(2'd2, rd); chk("R2 rise pending", rd, 32'h0008);
    chk("R7 irq on rise", {31'b0, irq_o}, 32'h1);
    chk("R8 vec src3", {24'b0, vec_o}, 32'h43);
    wr(2'd1, 32'h0008); settle(2);
    rdreg(2'd2, rd); chk("R5 clear rise", rd, 32'h0);
    chk("R7 irq after clear", {31'b0, irq_o}, 32'h0);
    gpio[3] = 1'b0; settle(6);
    rdreg(2'd2, rd); chk("R4 fall not enabled", rd, 32'h0);
  endtask

  task automatic t_fall;
    wr(2'd0, 32'h2000);
    gpio[5] = 1'b1; settle(6);
    rdreg(2'd2, rd); chk("R4 rise not enabled", rd, 32'h0);
    gpio[5] = 1'b0; settle(6);
    rdreg(2'd2, rd); chk("R3 fall pending", rd, 32'h2000);
    chk("R8 vec src5", {24'b0, vec_o}, 32'h45);
    chk("R7 irq on fall", {31'b0, irq_o}, 32'h1);
    wr(2'd1, 32'h0020); rdreg(2'd2, rd); chk("R5 wrong lane no effect", rd, 32'h2000);
    wr(2'd1, 32'h2000); rdreg(2'd2, rd); chk("R5 clear fall", rd, 32'h0);
  endtask

  task automatic t_both;
    wr(2'd0, 32'h0101);
    gpio[0] = 1'b1; settle(6);
    rdreg(2'd2, rd); chk("R2 both rise", rd, 32'h0001);
    gpio[0] = 1'b0; settle(6);
    rdreg(2'd2, rd); chk("R3 both fall", rd, 32'h0101);
    wr(2'd1, 32'h0001); rdreg(2'd2, rd); chk("R5 other flag kept", rd, 32'h0100);
    wr(2'd1, 32'h0100);
  endtask

  task automatic t_prio;
    wr(2'd0, 32'h0050);
    gpio[6] = 1'b1; settle(6);
    chk("R8 vec src6", {24'b0, vec_o}, 32'h46);
    gpio[4] = 1'b1; settle(6);
    chk("R8 lowest wins", {24'b0, vec_o}, 32'h44);
    wr(2'd1, 32'h0010); settle(2);
    chk("R8 back to src6", {24'b0, vec_o}, 32'h46);
    wr(2'd1, 32'h0040);
    gpio[4] = 1'b0; gpio[6] = 1'b0; settle(6);
  endtask

  task automatic t_mask;
    wr(2'd0, 32'h0002);
    gpio[1] = 1'b1; settle(6);
    chk("R7 irq set", {31'b0, irq_o}, 32'h1);
    wr(2'd0, 32'h0); settle(2);
    chk("R7 irq masked", {31'b0, irq_o}, 32'h0);
    rdreg(2'd2, rd); chk("R7 pending kept", rd, 32'h0002);
    wr(2'd0, 32'h0002); settle(2);
    chk("R7 irq unmasked", {31'b0, irq_o}, 32'h1);
    wr(2'd1, 32'h0002);
    gpio[1] = 1'b0; settle(6);
  endtask

  task automatic t_race;
    wr(2'd0, 32'h0004);
    gpio[2] = 1'b1; settle(6);
    gpio[2] = 1'b0; settle(6);
    rdreg(2'd2, rd); chk("R6 pre-set", rd, 32'h0004);
    @(negedge clk); gpio[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h0004;
    @(negedge clk);
    bus_wr = 1'b0;
    rdreg(2'd2, rd); chk("R6 edge beats clear", rd, 32'h0004);
    wr(2'd1, 32'h0004); rdreg(2'd2, rd); chk("R5 plain clear", rd, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle(1);
    t_reset;
    t_regs;
    t_rise;
    t_fall;
    t_both;
    t_prio;
    t_mask;
    t_race;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule